// File: doc/BRIEF.md
# Flash Operation Status Read Generator

This block sits on the read path of an embedded flash controller. While an internal program or erase operation is running, it substitutes status information for the normal array read data, so a host can learn when the operation has completed simply by reading any location. Two status indicators share the data bus. The completion-poll bit reports the inverse of the pending program data's bit 7, or a zero during an erase. The flip bit changes state on every read access while the operation is running.

The command decoder supplies three things: a busy flag, the operation kind captured when busy rises, and the data value latched for programming. The read interface supplies a single-cycle read strobe for each host access, and the array supplies its read data. When busy drops, the next read returns true array data on every bit. The flip bit then stops changing.

Top module: `flash_status_read`

## Requirements
- R1: While busy for a program operation, output bit 7 equals the inverse of bit 7 of the most recently loaded program data.
- R2: While busy for an erase operation (chip or sector), output bit 7 reads 0.
- R3: While busy, output bit 6 takes the opposite value on each successive read strobe. A read strobe is a one-cycle pulse per host access, formed upstream from an output-enable or chip-enable edge. Only alternation is defined; the absolute level is not.
- R4: While busy, bit 6 keeps its value on cycles with no read strobe.
- R5: When busy is low, the output equals the array read data on every bit, starting in the cycle in which busy falls.
- R6: A read in the same cycle that busy rises already returns status, with bit 7 chosen by the operation kind presented in that cycle.
- R7: While busy, every output bit other than 7 and 6 equals the array read data.
- R8: A data load strobe arriving while busy is ignored, and the previously loaded value stays in force.
- R9: After reset with busy low, the output equals the array read data.
- R10: The operation kind input (1 = erase, 0 = program) is sampled only in the cycle busy rises; changes to it later in the same busy period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Embedded program or erase in progress |
| opIsErase | input | 1 | Operation kind at busy rise: 1 erase, 0 program |
| loadValid | input | 1 | Strobe capturing loadData as program data |
| loadData | input | DATA_W | Data value to be programmed |
| readStrobe | input | 1 | One-cycle pulse per host read access |
| arrayData | input | DATA_W | True read data from the array |
| dataOut | output | DATA_W | Value returned on the data bus |

## Verification
The start of an operation and the first poll can fall in the same cycle. Busy rising, the operation kind and a read strobe are driven together, and the bench expects the status pattern at once rather than array data. A load strobe that coincides with busy is also provoked. The bench judges it by keeping the bit 7 expectation tied to the earlier loaded value. The cycle in which busy falls is read directly, and every bit is expected to match the array.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef struct packed {
    logic active;
    logic isErase;
    logic flipToggle;
    logic captureLoad;
  } statusStrobes_t;
endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           busy,
  input  logic           opIsErase,
  input  logic           loadValid,
  input  logic           readStrobe,
  output statusStrobes_t strobes
);
  logic busyQ;
  logic eraseQ;
  logic busyRise;

  assign busyRise = busy && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      eraseQ <= 1'b0;
    end else begin
      busyQ <= busy;
      if (busyRise) eraseQ <= opIsErase;
    end
  end

  always_comb begin
    strobes.active      = busy;
    strobes.isErase     = busyRise ? opIsErase : eraseQ;
    strobes.flipToggle  = busy && readStrobe;
    strobes.captureLoad = loadValid && !busy;
  end

  // R10: operation kind held for the whole busy period
  p_kind_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ) |=> (!busy || $stable(eraseQ)));
endmodule

// File: rtl/flash_status_datapath.sv
module flash_status_datapath
  import flash_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  statusStrobes_t    strobes,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] loadQ;
  logic              toggleQ;
  logic [DATA_W-1:0] composed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ   <= '1;
      toggleQ <= 1'b0;
    end else begin
      if (strobes.captureLoad) loadQ <= loadData;
      if (strobes.flipToggle)  toggleQ <= !toggleQ;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign composed[i] = strobes.isErase ? 1'b0 : !loadQ[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign composed[i] = toggleQ;
    end else begin : g_pass
      assign composed[i] = arrayData[i];
    end
  end

  assign dataOut = strobes.active ? composed : arrayData;

  // R8: program data frozen while busy
  p_load_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |=> $stable(loadQ));
  // R4: flip bit holds without a read
  p_toggle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flipToggle |=> $stable(toggleQ));
endmodule

// File: rtl/flash_status_read.sv
module flash_status_read
  import flash_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opIsErase,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic              readStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);
  statusStrobes_t strobes;

  flash_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busy(busy), .opIsErase(opIsErase),
    .loadValid(loadValid), .readStrobe(readStrobe), .strobes(strobes)
  );

  flash_status_datapath #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(loadData),
    .arrayData(arrayData), .dataOut(dataOut)
  );

  // R5: idle passes array data through
  p_idle_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dataOut == arrayData);
  // R3: each read while busy inverts the flip bit seen next cycle
  p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && readStrobe) |=> (!busy || dataOut[TOGGLE_BIT] != $past(dataOut[TOGGLE_BIT])));
  // R2 / R6: erase started this cycle reports zero at once
  p_erase_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy) && opIsErase) |-> !dataOut[POLL_BIT]);
endmodule

// File: tb/flash_status_read_tb.sv
module flash_status_read_tb;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rstN, busy, opIsErase, loadValid, readStrobe;
  logic [W-1:0] loadData, arrayData, dataOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_status_read u_dut (
    .clk(clk), .rstN(rstN), .busy(busy), .opIsErase(opIsErase),
    .loadValid(loadValid), .loadData(loadData), .readStrobe(readStrobe),
    .arrayData(arrayData), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // wait one edge, then move 1 ns away from it
  task automatic nextCycle();
    @(posedge clk); #1;
  endtask

  task automatic clearStrobes();
    loadValid = 0; readStrobe = 0;
  endtask

  task automatic loadProgData(input logic [W-1:0] d);
    loadData = d; loadValid = 1; nextCycle(); clearStrobes();
  endtask

  task automatic testReset();
    arrayData = 16'h3C5A; #1;
    check(dataOut == 16'h3C5A, "R9", dataOut, 16'h3C5A);
  endtask

  task automatic testProgram();
    logic prevTog;
    loadProgData(16'h0080);
    arrayData = 16'hA5A5;
    busy = 1; opIsErase = 0; readStrobe = 1; #1;
    check(dataOut[7] == 1'b0, "R6", dataOut, 16'h0000);
    check(dataOut[7] == 1'b0, "R1", dataOut, 16'h0000);
    check((dataOut & 16'hFF3F) == (16'hA5A5 & 16'hFF3F), "R7", dataOut, 16'hA5A5);
    prevTog = dataOut[6];
    for (int k = 0; k < 4; k++) begin
      nextCycle(); readStrobe = 1; #1;
      check(dataOut[6] != prevTog, "R3", {15'd0, dataOut[6]}, {15'd0, !prevTog});
      prevTog = dataOut[6];
    end
    nextCycle(); clearStrobes();
    prevTog = dataOut[6];
    for (int k = 0; k < 3; k++) begin
      nextCycle();
      check(dataOut[6] == prevTog, "R4", {15'd0, dataOut[6]}, {15'd0, prevTog});
    end
    loadData = 16'h0000; loadValid = 1; opIsErase = 1; arrayData = 16'h1234; #1;
    check(dataOut[7] == 1'b0, "R8", dataOut, 16'h0000);
    nextCycle(); clearStrobes(); readStrobe = 1; #1;
    check(dataOut[7] == 1'b0, "R8", dataOut, 16'h0000);
    check(dataOut[7] == 1'b0, "R10", dataOut, 16'h0000);
    check((dataOut & 16'hFF3F) == (16'h1234 & 16'hFF3F), "R7", dataOut, 16'h1234);
    nextCycle(); clearStrobes();
    busy = 0; arrayData = 16'hBEEF; readStrobe = 1; #1;
    check(dataOut == 16'hBEEF, "R5", dataOut, 16'hBEEF);
    nextCycle(); clearStrobes(); #1;
    check(dataOut == 16'hBEEF, "R5", dataOut, 16'hBEEF);
  endtask

  task automatic testProgramHigh();
    loadProgData(16'h007F);
    busy = 1; opIsErase = 0; arrayData = 16'h0000; #1;
    check(dataOut[7] == 1'b1, "R1", dataOut, 16'h0080);
    nextCycle(); opIsErase = 1; nextCycle(); #1;
    check(dataOut[7] == 1'b1, "R10", dataOut, 16'h0080);
    busy = 0; nextCycle();
  endtask

  task automatic testErase();
    logic prevTog;
    arrayData = 16'hFFFF;
    busy = 1; opIsErase = 1; readStrobe = 1; #1;
    check(dataOut[7] == 1'b0, "R2", dataOut, 16'hFF7F);
    check(dataOut[7] == 1'b0, "R6", dataOut, 16'hFF7F);
    prevTog = dataOut[6];
    for (int k = 0; k < 3; k++) begin
      nextCycle(); readStrobe = 1; opIsErase = 0; #1;
      check(dataOut[7] == 1'b0, "R2", dataOut, 16'hFF7F);
      check(dataOut[6] != prevTog, "R3", {15'd0, dataOut[6]}, {15'd0, !prevTog});
      prevTog = dataOut[6];
    end
    nextCycle(); clearStrobes(); busy = 0; #1;
    check(dataOut == 16'hFFFF, "R5", dataOut, 16'hFFFF);
    nextCycle();
  endtask

  initial begin
    rstN = 0; busy = 0; opIsErase = 0; loadData = '0; arrayData = '0;
    clearStrobes();
    repeat (3) nextCycle();
    testReset();
    rstN = 1; nextCycle();
    testReset();
    testProgram();
    testProgramHigh();
    testErase();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule